// File: doc/BRIEF.md
# Pulse-Width-Encoded Serial Bus Transceiver

This block is a single-channel serial transceiver for a two-wire sensor bus. A parallel word is sent as a frame of bits on a signal line. Each bit sets its value by how long the line stays low after the falling edge that opens the bit. In the same frame, the block reads one response bit per transmitted bit from a return line and assembles them into a received word.

A host loads the transmit word and the bit period, given in system clocks, and pulses a start strobe. The frame line goes low for the whole transfer. At the end, a one-cycle done strobe marks the received word as valid. A busy flag covers the transfer. A start request made while busy is dropped. The frame length is fixed per instance by a parameter.

Top module: `pulse_link_xcvr`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) puts `frameOut` and `sigOut` high and `busy` and `rxDone` low.
- R2: A `startReq` sampled while idle makes `busy` high and `frameOut` low from the next cycle. Both then hold for exactly FRAME_BITS × P cycles, where P is the bit period latched at start.
- R3: Every bit period opens with `sigOut` low in its first cycle, so each bit starts with a falling edge on `sigOut`.
- R4: A 0 bit drives `sigOut` low for the first 2P/3 cycles of its period and high for the last P/3 cycles.
- R5: A 1 bit drives `sigOut` low for the first P/3 cycles of its period and high for the last 2P/3 cycles.
- R6: Bits leave most-significant first: bit FRAME_BITS-1 of `txWord` goes in the first bit period.
- R7: `retIn` is sampled at the clock edge that ends each bit period. The first sample lands in `rxWord[FRAME_BITS-1]` and the last sample in `rxWord[0]`.
- R8: `rxDone` is high for exactly one cycle, the one following the edge that takes the final sample. In that cycle `busy` is low, `frameOut` is high and `rxWord` holds the whole response.
- R9: A `startReq` made while `busy` is ignored. The current frame keeps its timing and data, and no new frame follows it.
- R10: `bitPeriod` is latched at start and must be a multiple of 3 and at least 6. Changes made to it during a frame have no effect on that frame.
- R11: Between frames `sigOut` and `frameOut` stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Start strobe, taken only when idle |
| txWord | input | FRAME_BITS | Word to send, MSB first |
| bitPeriod | input | PERIOD_W | Bit period in clocks, multiple of 3, at least 6 |
| retIn | input | 1 | Return line, sampled at each bit end |
| sigOut | output | 1 | Pulse-width-encoded signal line, idles high |
| frameOut | output | 1 | Frame line, low during a transfer |
| rxWord | output | FRAME_BITS | Received response word |
| rxDone | output | 1 | One-cycle strobe, response valid |
| busy | output | 1 | Transfer in progress |

## Verification
The assertions assume that `bitPeriod` is a multiple of 3 and at least 6 whenever a start is accepted, because the one-third and two-thirds low times are only exact under that rule. They also assume `rst` is held for at least one edge before use. The stimulus draws every period as three times a random integer from 2 to 10. It changes `bitPeriod` and re-strobes `startReq` only in the middle of a frame, where both must be ignored. `retIn` changes only at the start of a bit period, so each sampled value is unambiguous.

// File: rtl/pulse_link_pkg.sv
package pulse_link_pkg;
  typedef struct packed {
    logic load;      // accept a new frame
    logic bitEnd;    // last cycle of a bit period
    logic finish;    // last cycle of the last bit
    logic lowShort;  // within first third of a bit, frame active
    logic lowLong;   // within first two thirds of a bit, frame active
  } linkCtlT;
endpackage

// File: rtl/pulse_link_ctrl.sv
module pulse_link_ctrl
  import pulse_link_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int PERIOD_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                startReq,
  input  logic [PERIOD_W-1:0] bitPeriod,
  output logic                busy,
  output linkCtlT             ctl
);
  localparam int IDX_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic [PERIOD_W-1:0] phaseCnt;
  logic [PERIOD_W-1:0] periodReg;
  logic [PERIOD_W-1:0] thirdReg;
  logic [IDX_W-1:0]    bitIdx;
  logic [PERIOD_W:0]   twoThird;
  logic                startOk;
  logic                bitEndNow;
  logic                lastBit;

  assign startOk   = startReq & ~busy;
  assign bitEndNow = busy & (phaseCnt == periodReg - 1'b1);
  assign lastBit   = (bitIdx == LAST_IDX);
  assign twoThird  = {thirdReg, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      phaseCnt  <= '0;
      periodReg <= '0;
      thirdReg  <= '0;
      bitIdx    <= '0;
    end else if (startOk) begin
      busy      <= 1'b1;
      phaseCnt  <= '0;
      bitIdx    <= '0;
      periodReg <= bitPeriod;
      thirdReg  <= bitPeriod / 3;
    end else if (busy) begin
      if (bitEndNow) begin
        phaseCnt <= '0;
        if (lastBit) busy <= 1'b0;
        else         bitIdx <= bitIdx + 1'b1;
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
      end
    end
  end

  always_comb begin
    ctl.load     = startOk;
    ctl.bitEnd   = bitEndNow;
    ctl.finish   = bitEndNow & lastBit;
    ctl.lowShort = busy & (phaseCnt < thirdReg);
    ctl.lowLong  = busy & ({1'b0, phaseCnt} < twoThird);
  end
endmodule

// File: rtl/pulse_link_dp.sv
module pulse_link_dp
  import pulse_link_pkg::*;
#(
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  linkCtlT               ctl,
  input  logic [FRAME_BITS-1:0] txWord,
  input  logic                  retIn,
  output logic                  sigOut,
  output logic [FRAME_BITS-1:0] rxWord,
  output logic                  rxDone
);
  logic [FRAME_BITS-1:0] txShift;
  logic [FRAME_BITS-1:0] rxShift;
  logic                  curBit;

  assign curBit = txShift[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      txShift <= '0;
      rxShift <= '0;
      rxDone  <= 1'b0;
    end else begin
      rxDone <= ctl.finish;
      if (ctl.load) begin
        txShift <= txWord;
        rxShift <= '0;
      end else if (ctl.bitEnd) begin
        txShift <= txShift << 1;
        if (FRAME_BITS > 1) rxShift <= {rxShift[FRAME_BITS-2:0], retIn};
        else                rxShift <= FRAME_BITS'(retIn);
      end
    end
  end

  // low for one third when sending 1, two thirds when sending 0
  assign sigOut = ~(ctl.lowShort | (ctl.lowLong & ~curBit));
  assign rxWord = rxShift;
endmodule

// File: rtl/pulse_link_xcvr.sv
module pulse_link_xcvr
  import pulse_link_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int PERIOD_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  startReq,
  input  logic [FRAME_BITS-1:0] txWord,
  input  logic [PERIOD_W-1:0]   bitPeriod,
  input  logic                  retIn,
  output logic                  sigOut,
  output logic                  frameOut,
  output logic [FRAME_BITS-1:0] rxWord,
  output logic                  rxDone,
  output logic                  busy
);
  linkCtlT ctl;

  pulse_link_ctrl #(.FRAME_BITS(FRAME_BITS), .PERIOD_W(PERIOD_W)) i_ctrl (
    .clk(clk), .rst(rst), .startReq(startReq), .bitPeriod(bitPeriod),
    .busy(busy), .ctl(ctl)
  );

  pulse_link_dp #(.FRAME_BITS(FRAME_BITS)) i_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .txWord(txWord), .retIn(retIn),
    .sigOut(sigOut), .rxWord(rxWord), .rxDone(rxDone)
  );

  assign frameOut = ~busy;
endmodule

// File: rtl/pulse_link_checker.sv
module pulse_link_checker #(
  parameter int FRAME_BITS = 16
) (
  input logic clk,
  input logic rst,
  input logic startReq,
  input logic sigOut,
  input logic frameOut,
  input logic rxDone,
  input logic busy
);
  assert_idle_lines_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (frameOut && sigOut));

  assert_frame_opens_low_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(frameOut) |-> !sigOut);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    rxDone |=> !rxDone);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    rxDone |-> (!busy && frameOut));

  assert_busy_ends_done_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || rxDone));

  assert_start_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && startReq) |=> (busy && !frameOut));
endmodule

bind pulse_link_xcvr pulse_link_checker #(.FRAME_BITS(FRAME_BITS)) i_checker (
  .clk(clk), .rst(rst), .startReq(startReq), .sigOut(sigOut),
  .frameOut(frameOut), .rxDone(rxDone), .busy(busy)
);

// File: tb/test_pulse_link_xcvr.sv
module test_pulse_link_xcvr;
  localparam int NB = 16;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          startReq = 1'b0;
  logic [NB-1:0] txWord = '0;
  logic [PW-1:0] bitPeriod = 8'd6;
  logic          retIn = 1'b0;
  logic          sigOut, frameOut, rxDone, busy;
  logic [NB-1:0] rxWord;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5ns clk = ~clk;

  pulse_link_xcvr #(.FRAME_BITS(NB), .PERIOD_W(PW)) i_pulse_link_xcvr (
    .clk(clk), .rst(rst), .startReq(startReq), .txWord(txWord),
    .bitPeriod(bitPeriod), .retIn(retIn), .sigOut(sigOut),
    .frameOut(frameOut), .rxWord(rxWord), .rxDone(rxDone), .busy(busy)
  );

  function automatic logic expSig(logic b, int c, int p);
    int lowLen;
    lowLen = b ? p / 3 : (2 * p) / 3;
    return (c < lowLen) ? 1'b0 : 1'b1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idleCycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R11 sigOut idle", 32'(sigOut), 32'd1);
      check("R11 frameOut idle", 32'(frameOut), 32'd1);
    end
  endtask

  // runs one frame; if poke, a busy-time start with other data and period is tried
  task automatic runFrame(logic [NB-1:0] tx, int p, logic [NB-1:0] resp, bit poke);
    int pokeBit;
    int frameCycles;
    pokeBit = $urandom_range(0, NB - 1);
    frameCycles = 0;
    @(negedge clk);
    startReq  = 1'b1;
    txWord    = tx;
    bitPeriod = PW'(p);
    for (int b = 0; b < NB; b++) begin
      for (int c = 0; c < p; c++) begin
        @(negedge clk);
        startReq = 1'b0;
        if (c == 0) retIn = resp[NB-1-b];
        if (poke && b == pokeBit && c == 1) begin
          startReq  = 1'b1;              // R9 ignored while busy
          txWord    = ~tx;
          bitPeriod = PW'(p + 3);        // R10 no effect mid-frame
        end
        frameCycles++;
        check("R2 busy", 32'(busy), 32'd1);
        check("R2 frameOut low", 32'(frameOut), 32'd0);
        if (c == 0) check("R3 bit opens low", 32'(sigOut), 32'd0);
        else if (tx[NB-1-b]) check("R5 R6 one-bit shape", 32'(sigOut), 32'(expSig(1'b1, c, p)));
        else check("R4 R6 zero-bit shape", 32'(sigOut), 32'(expSig(1'b0, c, p)));
      end
    end
    @(negedge clk);
    startReq = 1'b0;
    check("R2 frame length", 32'(frameCycles), 32'(NB * p));
    check("R8 done pulse", 32'(rxDone), 32'd1);
    check("R8 busy low at done", 32'(busy), 32'd0);
    check("R8 frameOut high at done", 32'(frameOut), 32'd1);
    check("R7 rxWord", 32'(rxWord), 32'(resp));
    @(negedge clk);
    check("R8 done one cycle", 32'(rxDone), 32'd0);
    check("R9 no extra frame", 32'(busy), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    @(negedge clk);
    check("R1 frameOut reset", 32'(frameOut), 32'd1);
    check("R1 sigOut reset", 32'(sigOut), 32'd1);
    check("R1 busy reset", 32'(busy), 32'd0);
    check("R1 rxDone reset", 32'(rxDone), 32'd0);
    rst = 1'b0;
    idleCycles(3);
    runFrame(16'h0000, 6, 16'hFFFF, 1'b0);
    idleCycles(2);
    runFrame(16'hFFFF, 6, 16'h0001, 1'b0);
    idleCycles(1);
    runFrame(16'hA5C3, 9, 16'h8000, 1'b1);
    runFrame(16'h8001, 30, 16'h5A3C, 1'b1);
    for (int k = 0; k < 10; k++) begin
      runFrame(NB'($urandom), 3 * $urandom_range(2, 10), NB'($urandom), k[0]);
      idleCycles($urandom_range(0, 3));
    end
    // mid-frame reset returns to idle
    @(negedge clk);
    startReq  = 1'b1;
    txWord    = 16'h1234;
    bitPeriod = 8'd12;
    @(negedge clk);
    startReq = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset aborts busy", 32'(busy), 32'd0);
    check("R1 reset frameOut", 32'(frameOut), 32'd1);
    check("R1 reset sigOut", 32'(sigOut), 32'd1);
    rst = 1'b0;
    idleCycles(2);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule